// File: doc/BRIEF.md
# Gate driver protection fault controller

This block sits between a PWM source and a low-side gate drive stage. It passes the PWM level to the drive output only while a shared open-drain enable/fault line reads high and no protection fault is latched. The same line carries the fault report back: when the block detects a fault, it asks for the line to be pulled low. The analog parts around it are seen only as digital flags. These are an over-current comparator result, a supply-low comparator result and the resolved level of the shared line.

Over-current is looked at only while the output is driving and only after a blanking window that restarts at every turn-on. This keeps the switching transient from tripping a fault. A supply-low indication must persist through a filter window before it counts. Either fault turns the output off, and the pull-down request stays on for a fault-clear time. That time is a cycle count loaded at the moment the fault latches. The pull-down is dropped only when this count has run out and the cause has gone away. A status output shows which cause is latched.

Top module: `gd_prot_ctrl`

## Requirements
- R1: With the shared line high and no fault latched, `drv_out` equals `in_pwm` two clock cycles after `in_pwm` changes (two-flop synchronisers). In every other case `drv_out` is 0.
- R2: An external low on the shared line forces `drv_out` to 0 only while the line stays low. This does not latch: no fault is recorded, `pull_dn` stays 0, and the output follows `in_pwm` again once the line is high.
- R3: The synchronised over-current flag is ignored during the first BLANK_CYC cycles of every high period of `drv_out`. A flag that rises and falls inside that window latches nothing.
- R4: An over-current flag that is high while `drv_out` is high and blanking has ended latches a fault on the next edge. At that point `fault_cause` bit 0 (over-current) is 1, `pull_dn` is 1 and `drv_out` is 0, whatever the level of `in_pwm`.
- R5: A supply-low fault latches only after the synchronised supply-low flag has been high for UV_FILT_CYC+1 consecutive cycles. A flag that is high for UV_FILT_CYC cycles or fewer is ignored, and a low restarts the count.
- R6: A latched supply-low fault sets `fault_cause` bit 1 (undervoltage), sets `pull_dn` to 1 and holds `drv_out` at 0, even with `in_pwm` high.
- R7: In reset and after it, the block reports an undervoltage fault (`fault_cause` = 2, `pull_dn` = 1, `drv_out` = 0). This state clears once the synchronised supply-low flag reads low.
- R8: A latched fault is released only when two things hold: the clear timer has reached zero, and every latched cause is gone (over-current flag low and/or supply-low flag low). If the cause outlasts the timer, the release follows the end of the cause within three cycles.
- R9: The clear time is `clr_cycles`, sampled at the moment a fault latches. When the cause is already gone, `pull_dn` stays high for exactly `clr_cycles`+1 cycles, so the hold time grows one for one with the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pwm | input | 1 | PWM logic input, asynchronous |
| oc_flag | input | 1 | Over-current comparator result, asynchronous |
| uv_flag | input | 1 | Supply-low comparator result, asynchronous |
| en_line | input | 1 | Resolved level of the shared open-drain enable/fault line |
| clr_cycles | input | CLR_W | Fault-clear time in clock cycles |
| drv_out | output | 1 | Gated drive enable to the output stage |
| pull_dn | output | 1 | Request to pull the shared line low |
| fault_cause | output | 2 | Latched cause: bit 0 over-current, bit 1 undervoltage |

## Verification
A blanking counter that was not cleared while the output was off would let an over-current pulse at the start of a new turn-on latch a fault. That fault would show on `fault_cause` and `pull_dn` within three cycles of the flag. A clear timer loaded with the wrong count, or one that does not wait for the cause to end, would move the falling edge of `pull_dn` away from its predicted cycle. The reference model in the bench tracks the expected output on every clock, so such an error is caught in the first cycle it appears. A supply filter that is off by one shows up at the UV_FILT_CYC and UV_FILT_CYC+1 boundary pulses as a missing or extra undervoltage fault.

// File: rtl/gd_prot_pkg.sv
package gd_prot_pkg;

  typedef struct packed {
    logic uv;
    logic oc;
  } cause_t;

  localparam int CAUSE_W = $bits(cause_t);

  // synchroniser bit positions
  localparam int SB_IN = 0;
  localparam int SB_OC = 1;
  localparam int SB_UV = 2;
  localparam int SB_EN = 3;
  localparam int SB_W  = 4;

endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d_async;
      end else begin : g_rest
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/gd_blank.sv
module gd_blank #(
  parameter int BLANK_CYC = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_on,
  output logic armed
);

  localparam int CW = $clog2(BLANK_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // counter is held at zero while the drive is off, so every turn-on restarts it
  assign cnt_en = !drv_on || (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!drv_on)             cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed = drv_on && (cnt_q == LIMIT);

endmodule

// File: rtl/gd_uv_filt.sv
module gd_uv_filt #(
  parameter int FILT_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_s,
  output logic trip
);

  localparam int CW = $clog2(FILT_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !uv_s || (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!uv_s)               cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip = uv_s && (cnt_q == LIMIT);

endmodule

// File: rtl/gd_fault_ctl.sv
module gd_fault_ctl
  import gd_prot_pkg::*;
#(
  parameter int CLR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_trip,
  input  logic             uv_trip,
  input  logic             oc_s,
  input  logic             uv_s,
  input  logic [CLR_W-1:0] clr_cycles,
  output cause_t           cause,
  output logic             tmr_zero
);

  cause_t           cause_q, cause_d;
  logic [CLR_W-1:0] tmr_q, tmr_d;
  logic             set_oc, set_uv, any_q, cond_gone, release_ok;
  logic             st_en;

  assign any_q      = cause_q.oc || cause_q.uv;
  assign set_oc     = oc_trip && !cause_q.oc;
  assign set_uv     = uv_trip && !cause_q.uv;
  assign tmr_zero   = (tmr_q == '0);
  assign cond_gone  = (!cause_q.oc || !oc_s) && (!cause_q.uv || !uv_s);
  assign release_ok = any_q && tmr_zero && cond_gone;

  always_comb begin
    cause_d = cause_q;
    tmr_d   = tmr_q;
    if (set_oc || set_uv) begin
      cause_d.oc = cause_q.oc || set_oc;
      cause_d.uv = cause_q.uv || set_uv;
      tmr_d      = clr_cycles;
    end else if (release_ok) begin
      cause_d = '0;
    end else if (any_q && !tmr_zero) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  assign st_en = set_oc || set_uv || any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '{uv: 1'b1, oc: 1'b0};
      tmr_q   <= '0;
    end else if (st_en) begin
      cause_q <= cause_d;
      tmr_q   <= tmr_d;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/gd_prot_ctrl.sv
module gd_prot_ctrl
  import gd_prot_pkg::*;
#(
  parameter int BLANK_CYC   = 23,
  parameter int UV_FILT_CYC = 250,
  parameter int CLR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_pwm,
  input  logic             oc_flag,
  input  logic             uv_flag,
  input  logic             en_line,
  input  logic [CLR_W-1:0] clr_cycles,
  output logic             drv_out,
  output logic             pull_dn,
  output logic [1:0]       fault_cause
);

  localparam logic [SB_W-1:0] SYNC_RST = SB_W'(1) << SB_UV;

  logic [SB_W-1:0] raw, syn;
  logic            s_in, s_oc, s_uv, s_en;
  logic            blank_armed, oc_trip, uv_trip, tmr_zero;
  cause_t          cause;

  always_comb begin
    raw        = '0;
    raw[SB_IN] = in_pwm;
    raw[SB_OC] = oc_flag;
    raw[SB_UV] = uv_flag;
    raw[SB_EN] = en_line;
  end

  gd_sync #(.W(SB_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw),
    .q_sync  (syn)
  );

  assign s_in = syn[SB_IN];
  assign s_oc = syn[SB_OC];
  assign s_uv = syn[SB_UV];
  assign s_en = syn[SB_EN];

  assign drv_out = s_in && s_en && !cause.oc && !cause.uv;

  gd_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .drv_on (drv_out),
    .armed  (blank_armed)
  );

  assign oc_trip = s_oc && blank_armed;

  gd_uv_filt #(.FILT_CYC(UV_FILT_CYC)) u_uvf (
    .clk   (clk),
    .rst_n (rst_n),
    .uv_s  (s_uv),
    .trip  (uv_trip)
  );

  gd_fault_ctl #(.CLR_W(CLR_W)) u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_trip    (oc_trip),
    .uv_trip    (uv_trip),
    .oc_s       (s_oc),
    .uv_s       (s_uv),
    .clr_cycles (clr_cycles),
    .cause      (cause),
    .tmr_zero   (tmr_zero)
  );

  assign pull_dn     = cause.oc || cause.uv;
  assign fault_cause = {cause.uv, cause.oc};

endmodule

// File: rtl/gd_prot_chk.sv
module gd_prot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drv_out,
  input logic       pull_dn,
  input logic [1:0] fault_cause,
  input logic       s_oc,
  input logic       s_uv,
  input logic       blank_armed,
  input logic       tmr_zero
);

  AST_OC_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_cause[0]) |-> $past(blank_armed));  // R3

  AST_OC_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_cause[0]) |-> ($past(drv_out) && $past(s_oc)));  // R4

  AST_UV_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_cause[1]) |-> $past(s_uv));  // R5

  AST_RELEASE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_dn) |-> $past(tmr_zero));  // R8

  AST_RELEASE_OC_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_cause[0]) |-> !$past(s_oc));  // R8

  AST_RELEASE_UV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_cause[1]) |-> !$past(s_uv));  // R7

endmodule

bind gd_prot_ctrl gd_prot_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drv_out     (drv_out),
  .pull_dn     (pull_dn),
  .fault_cause (fault_cause),
  .s_oc        (s_oc),
  .s_uv        (s_uv),
  .blank_armed (blank_armed),
  .tmr_zero    (tmr_zero)
);

// File: tb/gd_prot_ctrl_bench.sv
module gd_prot_ctrl_bench;

  localparam int BLANK = 23;
  localparam int UVF   = 250;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst_n, in_pwm, oc_flag, uv_flag, ext_low;
  logic [CW-1:0] clr;
  logic          drv_out, pull_dn, en_line;
  logic [1:0]    fault_cause;
  int            tests = 0;
  int            fails = 0;

  always #4 clk = ~clk;

  // open-drain line with external pull-up
  assign en_line = !ext_low && !pull_dn;

  gd_prot_ctrl #(.BLANK_CYC(BLANK), .UV_FILT_CYC(UVF), .CLR_W(CW)) u_gd_prot_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_pwm      (in_pwm),
    .oc_flag     (oc_flag),
    .uv_flag     (uv_flag),
    .en_line     (en_line),
    .clr_cycles  (clr),
    .drv_out     (drv_out),
    .pull_dn     (pull_dn),
    .fault_cause (fault_cause)
  );

  // behavioural reference model
  logic m_in [2];
  logic m_oc [2];
  logic m_uv [2];
  logic m_en [2];
  logic m_foc, m_fuv;
  int   m_tmr, m_hi, m_uvr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= '{0, 0}; m_oc <= '{0, 0}; m_en <= '{0, 0}; m_uv <= '{1, 1};
      m_foc <= 1'b0; m_fuv <= 1'b1; m_tmr <= 0; m_hi <= 0; m_uvr <= 0;
    end else begin
      logic drv, t_oc, t_uv, set_oc, set_uv, gone;
      drv    = m_in[1] && m_en[1] && !m_foc && !m_fuv;
      t_oc   = m_oc[1] && drv && (m_hi >= BLANK);
      t_uv   = m_uv[1] && (m_uvr >= UVF);
      set_oc = t_oc && !m_foc;
      set_uv = t_uv && !m_fuv;
      gone   = (!m_foc || !m_oc[1]) && (!m_fuv || !m_uv[1]);
      m_in <= '{in_pwm, m_in[0]};
      m_oc <= '{oc_flag, m_oc[0]};
      m_uv <= '{uv_flag, m_uv[0]};
      m_en <= '{en_line, m_en[0]};
      m_hi  <= drv ? m_hi + 1 : 0;
      m_uvr <= m_uv[1] ? m_uvr + 1 : 0;
      if (set_oc || set_uv) begin
        m_foc <= m_foc || set_oc;
        m_fuv <= m_fuv || set_uv;
        m_tmr <= int'(clr);
      end else if ((m_foc || m_fuv) && m_tmr == 0 && gone) begin
        m_foc <= 1'b0;
        m_fuv <= 1'b0;
      end else if ((m_foc || m_fuv) && m_tmr > 0) begin
        m_tmr <= m_tmr - 1;
      end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 drive vs model", int'(drv_out), int'(m_in[1] && m_en[1] && !m_foc && !m_fuv));
      chk("R8 pull-down vs model", int'(pull_dn), int'(m_foc || m_fuv));
      chk("R4 cause vs model", int'(fault_cause), int'({m_fuv, m_foc}));
    end
  end

  task automatic oc_fault_duration(input int c, output int n);
    clr = CW'(c);
    in_pwm = 1'b1; cyc(40);
    oc_flag = 1'b1; cyc(3);
    oc_flag = 1'b0;
    n = 0;
    while (pull_dn && n < 1000) begin
      n++;
      cyc(1);
    end
    in_pwm = 1'b0; cyc(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d_lo, d_hi;
    rst_n = 1'b0; in_pwm = 1'b0; oc_flag = 1'b0; uv_flag = 1'b0;
    ext_low = 1'b0; clr = CW'(30);
    cyc(3);
    chk("R7 reset drv", int'(drv_out), 0);
    chk("R7 reset pull", int'(pull_dn), 1);
    chk("R7 reset cause", int'(fault_cause), 2);
    rst_n = 1'b1;
    cyc(1);
    chk("R7 still held after reset", int'(pull_dn), 1);
    cyc(4);
    chk("R7 released pull", int'(pull_dn), 0);
    chk("R7 released cause", int'(fault_cause), 0);

    // R1 follow and latency
    cyc(3);
    in_pwm = 1'b1; cyc(1);
    chk("R1 one cycle latency low", int'(drv_out), 0);
    cyc(1);
    chk("R1 two cycle latency high", int'(drv_out), 1);
    in_pwm = 1'b0; cyc(3);
    chk("R1 follows low", int'(drv_out), 0);

    // R2 external disable, not latched
    ext_low = 1'b1; in_pwm = 1'b1; cyc(4);
    chk("R2 disabled drv", int'(drv_out), 0);
    chk("R2 no pull", int'(pull_dn), 0);
    chk("R2 no cause", int'(fault_cause), 0);
    ext_low = 1'b0; cyc(3);
    chk("R2 resumes", int'(drv_out), 1);
    in_pwm = 1'b0; cyc(3);

    // R3 over-current inside blanking
    in_pwm = 1'b1; cyc(2);
    oc_flag = 1'b1; cyc(10);
    oc_flag = 1'b0; cyc(30);
    chk("R3 blanked no cause", int'(fault_cause), 0);
    chk("R3 blanked drive kept", int'(drv_out), 1);
    in_pwm = 1'b0; cyc(3);

    // R4 over-current after blanking, R8 minimum hold
    clr = CW'(30);
    in_pwm = 1'b1; cyc(40);
    oc_flag = 1'b1; cyc(3);
    chk("R4 cause oc", int'(fault_cause), 1);
    chk("R4 pull on", int'(pull_dn), 1);
    chk("R4 drive off", int'(drv_out), 0);
    oc_flag = 1'b0; cyc(15);
    chk("R8 held by timer", int'(pull_dn), 1);
    cyc(30);
    chk("R8 released", int'(pull_dn), 0);
    chk("R8 drive resumes", int'(drv_out), 1);
    in_pwm = 1'b0; cyc(3);

    // R8 cause outlasts the timer
    clr = CW'(10);
    in_pwm = 1'b1; cyc(40);
    oc_flag = 1'b1; cyc(60);
    chk("R8 held by cause", int'(pull_dn), 1);
    oc_flag = 1'b0; cyc(2);
    chk("R8 not yet released", int'(pull_dn), 1);
    cyc(2);
    chk("R8 released after cause", int'(pull_dn), 0);
    in_pwm = 1'b0; cyc(3);

    // R5 filter boundaries, R6 undervoltage fault
    uv_flag = 1'b1; cyc(100);
    uv_flag = 1'b0; cyc(5);
    chk("R5 short dip ignored", int'(fault_cause), 0);
    uv_flag = 1'b1; cyc(UVF);
    uv_flag = 1'b0; cyc(5);
    chk("R5 boundary dip ignored", int'(fault_cause), 0);
    in_pwm = 1'b1; cyc(5);
    uv_flag = 1'b1; cyc(UVF + 1);
    uv_flag = 1'b0; cyc(3);
    chk("R5 filtered trip", int'(fault_cause), 2);
    chk("R6 pull on", int'(pull_dn), 1);
    chk("R6 drive off with in high", int'(drv_out), 0);
    cyc(20);
    chk("R8 uv released", int'(fault_cause), 0);
    in_pwm = 1'b0; cyc(3);

    // R9 hold time scales with programmed value
    oc_fault_duration(20, d_lo);
    oc_fault_duration(60, d_hi);
    chk("R9 hold equals clr+1", d_lo, 21);
    chk("R9 linear scaling", d_hi - d_lo, 40);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule